// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches a bank of general-purpose input pins and turns activity on them into latched interrupt requests. Each pin is brought into the clock domain through a two-stage synchronizer. A per-pin mode bit then selects how the synchronized value is judged: either as a level that must match an active value, or as a transition in one direction. A per-pin active bit picks the direction of that transition or the asserted level. A recognized event sets the pin's pending bit, which stays set until software acknowledges it.

Software reaches the controller through a flat 32-bit register port with a combinational read path. Pins are packed 32 to a word. Every configuration field (mask, mode, active level, software force and the two domain enables) can be read. The four per-pin fields can also be changed through separate write-one-to-set and write-one-to-clear aliases. Pending bits are observed through a read-only status view and cleared through a separate acknowledge view. A single interrupt line is high whenever some pin is pending, unmasked and enabled for domain 0. Firmware can also leave that line unused and poll the status view.

Top module: `xint_ctrl`

## Requirements
- R1: After reset, every pending bit, mode bit, active bit, force bit and both domain enables read 0, and every implemented pin reads 1 in the mask view. The line irq_o is low.
- R2: The register map uses byte addresses. View group g sits at g*0x40, and word w of a group sits at +4*w, holding pins 32*w to 32*w+31 with pin n at bit n%32. The group numbers are: 0 status, 1 acknowledge, 2 mask, 3 mask-set, 4 mask-clear, 5 mode, 6 mode-set, 7 mode-clear, 8 force, 9 force-set, 10 force-clear, 12 active, 13 active-set and 14 active-clear. Groups 11 and 15 are reserved, read 0 and ignore writes.
- R3: Writing a 1 to a bit of a set alias sets that field bit, and writing a 1 to a clear alias clears it; bits written as 0 change nothing. The set and clear aliases read back the field value. Writes to the plain mask, mode, force and active views are ignored.
- R4: With mode 0 (edge), a pin whose active bit is 1 becomes pending on a 0-to-1 transition, and one whose active bit is 0 on a 1-to-0 transition. The pin stays pending after the input returns.
- R5: With mode 1 (level), a pin is pending while its input equals its active bit. An acknowledge while that level persists leaves the pin pending; once the level is gone, an acknowledge clears it.
- R6: An input change applied before clock edge k is visible in the status view after edge k+2 and not after edge k+1.
- R7: Writing a 1 to an acknowledge bit clears that pin's pending bit; 0 bits have no effect. Writes to the status view are ignored.
- R8: In edge mode, when a new transition is recognized in the same cycle as the acknowledge of that pin, the pin stays pending.
- R9: A set force bit keeps its pin pending, and an acknowledge does not clear that pin. After force-clear, an acknowledge clears the pin.
- R10: irq_o is high exactly when some pin is pending, has mask 0 and has its domain-0 enable at 1. The domain-1 enable has no effect on irq_o. The domain-0 enable is read and written directly at byte 0x400+4*w and the domain-1 enable at 0x420+4*w.
- R11: Bits above NUM_PINS-1, and words at or beyond ceil(NUM_PINS/32) in any view, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | NUM_PINS | Monitored pin inputs, asynchronous |
| bus_wr_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | 11 | Register byte address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i, combinational |
| irq_o | output | 1 | Combined interrupt request for domain 0 |

## Verification
A corrupted pending bit appears in the status view on the next read and on irq_o in the same cycle, provided the pin is unmasked and enabled. A lost configuration bit changes how the next pin transition is judged, so the status view is wrong about three cycles after that input change. Register corruption is seen directly by reading back the field or its aliases, which the random part of the bench does after every write. The same-cycle ordering between a new transition and its acknowledge shows at the status port one cycle after the write.

// File: rtl/xint_pkg.sv
package xint_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned MAX_WORDS = 7;
  localparam int unsigned NFIELDS   = 6;

  // View groups, 0x40 bytes apart.
  typedef enum logic [3:0] {
    GRP_PEND      = 4'd0,
    GRP_ACK       = 4'd1,
    GRP_MASK      = 4'd2,
    GRP_MASK_SET  = 4'd3,
    GRP_MASK_CLR  = 4'd4,
    GRP_MODE      = 4'd5,
    GRP_MODE_SET  = 4'd6,
    GRP_MODE_CLR  = 4'd7,
    GRP_FRC       = 4'd8,
    GRP_FRC_SET   = 4'd9,
    GRP_FRC_CLR   = 4'd10,
    GRP_HOLE_A    = 4'd11,
    GRP_ACTV      = 4'd12,
    GRP_ACTV_SET  = 4'd13,
    GRP_ACTV_CLR  = 4'd14,
    GRP_HOLE_B    = 4'd15
  } grp_e;

  typedef enum logic [2:0] {
    F_MASK = 3'd0,
    F_MODE = 3'd1,
    F_FRC  = 3'd2,
    F_ACTV = 3'd3,
    F_DOM0 = 3'd4,
    F_DOM1 = 3'd5,
    F_NONE = 3'd6
  } field_e;

  typedef enum logic [2:0] {
    K_NONE = 3'd0,
    K_STAT = 3'd1,
    K_ACK  = 3'd2,
    K_VIEW = 3'd3,
    K_SET  = 3'd4,
    K_CLR  = 3'd5,
    K_LOAD = 3'd6
  } kind_e;

  typedef struct packed {
    field_e     fld;
    kind_e      kind;
    logic [2:0] word;
  } acc_t;

endpackage

// File: rtl/xint_decode.sv
module xint_decode
  import xint_pkg::*;
#(
  parameter int unsigned NWORDS = 2
) (
  input  logic [10:0] addr_i,
  output acc_t        acc_o
);

  logic [3:0] idx;
  logic [3:0] hi_idx;
  grp_e       grp;
  logic [1:0] unused_lsb;

  assign idx        = addr_i[5:2];
  assign hi_idx     = 4'(idx - 4'd8);
  assign grp        = grp_e'(addr_i[9:6]);
  assign unused_lsb = addr_i[1:0];

  always_comb begin
    acc_o.fld  = F_NONE;
    acc_o.kind = K_NONE;
    acc_o.word = 3'd0;
    if (!addr_i[10]) begin
      if (32'(idx) < NWORDS) begin
        acc_o.word = idx[2:0];
        case (grp)
          GRP_PEND:     acc_o.kind = K_STAT;
          GRP_ACK:      acc_o.kind = K_ACK;
          GRP_MASK:     begin acc_o.fld = F_MASK; acc_o.kind = K_VIEW; end
          GRP_MASK_SET: begin acc_o.fld = F_MASK; acc_o.kind = K_SET;  end
          GRP_MASK_CLR: begin acc_o.fld = F_MASK; acc_o.kind = K_CLR;  end
          GRP_MODE:     begin acc_o.fld = F_MODE; acc_o.kind = K_VIEW; end
          GRP_MODE_SET: begin acc_o.fld = F_MODE; acc_o.kind = K_SET;  end
          GRP_MODE_CLR: begin acc_o.fld = F_MODE; acc_o.kind = K_CLR;  end
          GRP_FRC:      begin acc_o.fld = F_FRC;  acc_o.kind = K_VIEW; end
          GRP_FRC_SET:  begin acc_o.fld = F_FRC;  acc_o.kind = K_SET;  end
          GRP_FRC_CLR:  begin acc_o.fld = F_FRC;  acc_o.kind = K_CLR;  end
          GRP_ACTV:     begin acc_o.fld = F_ACTV; acc_o.kind = K_VIEW; end
          GRP_ACTV_SET: begin acc_o.fld = F_ACTV; acc_o.kind = K_SET;  end
          GRP_ACTV_CLR: begin acc_o.fld = F_ACTV; acc_o.kind = K_CLR;  end
          default:      acc_o.kind = K_NONE;
        endcase
      end
    end else if (addr_i[9:6] == 4'd0) begin
      if (idx < 4'd8) begin
        if (32'(idx) < NWORDS) begin
          acc_o.fld  = F_DOM0;
          acc_o.kind = K_LOAD;
          acc_o.word = idx[2:0];
        end
      end else if (32'(hi_idx) < NWORDS) begin
        acc_o.fld  = F_DOM1;
        acc_o.kind = K_LOAD;
        acc_o.word = hi_idx[2:0];
      end
    end
  end

endmodule

// File: rtl/xint_w1reg.sv
module xint_w1reg #(
  parameter int unsigned   W       = 32,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_d;
  logic         en;

  always_comb begin
    en  = |(set_i | clr_i);
    q_d = (q_r | set_i) & ~clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_r <= RST_VAL;
    end else if (en) begin
      q_r <= q_d;
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/xint_insync.sv
module xint_insync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pins_i,
  output logic [W-1:0] now_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] now_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      now_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pins_i;
      now_q  <= meta_q;
      prev_q <= now_q;
    end
  end

  assign now_o  = now_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/xint_pend.sv
module xint_pend #(
  parameter int unsigned  W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] now_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] actv_i,
  input  logic [W-1:0] frc_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] pend_o
);

  logic [W-1:0] pend_q;
  logic [W-1:0] pend_d;
  logic [W-1:0] hit;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic lvl_hit;
    logic rise;
    logic fall;
    logic edg_hit;
    always_comb begin
      lvl_hit = mode_i[i] & ~(now_i[i] ^ actv_i[i]);
      rise    = now_i[i] & ~prev_i[i];
      fall    = ~now_i[i] & prev_i[i];
      edg_hit = ~mode_i[i] & (actv_i[i] ? rise : fall);
      hit[i]  = (lvl_hit | edg_hit | frc_i[i]) & VALID[i];
    end
  end

  // A new event outranks an acknowledge in the same cycle.
  always_comb begin
    pend_d = (hit | (pend_q & ~ack_i)) & VALID;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/xint_ctrl.sv
module xint_ctrl
  import xint_pkg::*;
#(
  parameter int unsigned NUM_PINS = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                bus_wr_i,
  input  logic [10:0]         bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  output logic                irq_o
);

  localparam int unsigned NWORDS = (NUM_PINS + WORD_W - 1) / WORD_W;
  localparam int unsigned PAD_W  = NWORDS * WORD_W;
  localparam logic [PAD_W-1:0] VALID = PAD_W'({NUM_PINS{1'b1}});

  // Reset: asserted at once, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  // Access decode
  acc_t acc;

  xint_decode #(.NWORDS(NWORDS)) u_decode (
    .addr_i (bus_addr_i),
    .acc_o  (acc)
  );

  logic [PAD_W-1:0] placed;
  logic [PAD_W-1:0] placed_inv;
  logic [7:0]       shamt;

  assign shamt      = {acc.word, 5'b00000};
  assign placed     = (PAD_W'(bus_wdata_i) << shamt) & VALID;
  assign placed_inv = (PAD_W'(~bus_wdata_i) << shamt) & VALID;

  logic [PAD_W-1:0] f_set [NFIELDS];
  logic [PAD_W-1:0] f_clr [NFIELDS];
  logic [PAD_W-1:0] f_q   [NFIELDS];
  logic [PAD_W-1:0] ack_v;

  always_comb begin
    for (int f = 0; f < NFIELDS; f++) begin
      f_set[f] = '0;
      f_clr[f] = '0;
      if (bus_wr_i && (acc.fld == field_e'(3'(f)))) begin
        case (acc.kind)
          K_SET:  f_set[f] = placed;
          K_CLR:  f_clr[f] = placed;
          K_LOAD: begin
            f_set[f] = placed;
            f_clr[f] = placed_inv;
          end
          default: begin
            f_set[f] = '0;
            f_clr[f] = '0;
          end
        endcase
      end
    end
    ack_v = (bus_wr_i && (acc.kind == K_ACK)) ? placed : '0;
  end

  // Configuration fields; the mask resets to all implemented pins masked.
  for (genvar g = 0; g < NFIELDS; g++) begin : g_fld
    localparam logic [PAD_W-1:0] RV = (g == int'(F_MASK)) ? VALID : {PAD_W{1'b0}};
    xint_w1reg #(.W(PAD_W), .RST_VAL(RV)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_sync_n),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .q_o    (f_q[g])
    );
  end

  logic [PAD_W-1:0] mask_q;
  logic [PAD_W-1:0] mode_q;
  logic [PAD_W-1:0] frc_q;
  logic [PAD_W-1:0] actv_q;
  logic [PAD_W-1:0] dom0_q;

  assign mask_q = f_q[int'(F_MASK)];
  assign mode_q = f_q[int'(F_MODE)];
  assign frc_q  = f_q[int'(F_FRC)];
  assign actv_q = f_q[int'(F_ACTV)];
  assign dom0_q = f_q[int'(F_DOM0)];

  // Input capture and event latching
  logic [PAD_W-1:0] sync_now;
  logic [PAD_W-1:0] sync_prev;
  logic [PAD_W-1:0] pend_q;

  xint_insync #(.W(PAD_W)) u_insync (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .pins_i (PAD_W'(pins_i)),
    .now_o  (sync_now),
    .prev_o (sync_prev)
  );

  xint_pend #(.W(PAD_W), .VALID(VALID)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .now_i  (sync_now),
    .prev_i (sync_prev),
    .mode_i (mode_q),
    .actv_i (actv_q),
    .frc_i  (frc_q),
    .ack_i  (ack_v),
    .pend_o (pend_q)
  );

  // Read path
  logic [PAD_W-1:0] rd_src;
  logic [PAD_W-1:0] rd_shift;

  always_comb begin
    rd_src = '0;
    case (acc.kind)
      K_STAT: rd_src = pend_q;
      K_VIEW, K_SET, K_CLR, K_LOAD: begin
        for (int f = 0; f < NFIELDS; f++) begin
          if (acc.fld == field_e'(3'(f))) begin
            rd_src = f_q[f];
          end
        end
      end
      default: rd_src = '0;
    endcase
  end

  assign rd_shift    = rd_src >> shamt;
  assign bus_rdata_o = rd_shift[31:0];

  assign irq_o = |(pend_q & ~mask_q & dom0_q);

endmodule

// File: rtl/xint_chk.sv
module xint_chk #(
  parameter int unsigned  W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         irq_o,
  input logic [W-1:0] pend,
  input logic [W-1:0] mask,
  input logic [W-1:0] mode,
  input logic [W-1:0] actv,
  input logic [W-1:0] frc,
  input logic [W-1:0] dom0,
  input logic [W-1:0] ack,
  input logic [W-1:0] now
);

  // R7: a pending bit only falls when it was acknowledged
  a_r7_pend_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pend) & ~$past(ack) & ~pend) == '0));

  // R9: a forced pin is pending one cycle later
  a_r9_force_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(frc) & ~pend) == '0));

  // R5: a pin held at its active level in level mode is pending next cycle
  a_r5_level_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(mode & ~(now ^ actv)) & ~pend) == '0));

  // R10: no unmasked pending pin, no request
  a_r10_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend & ~mask) == '0) |-> !irq_o);

  // R10: domain 0 fully disabled, no request
  a_r10_dom_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dom0 == '0) |-> !irq_o);

  // R11: unimplemented pins never hold state
  a_r11_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend | mode | actv | frc | dom0 | mask) & ~VALID) == '0);

endmodule

bind xint_ctrl xint_chk #(.W(PAD_W), .VALID(VALID)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_sync_n),
  .irq_o  (irq_o),
  .pend   (pend_q),
  .mask   (mask_q),
  .mode   (mode_q),
  .actv   (actv_q),
  .frc    (frc_q),
  .dom0   (dom0_q),
  .ack    (ack_v),
  .now    (sync_now)
);

// File: tb/test_xint_ctrl.sv
`timescale 1ns/1ps
module test_xint_ctrl;

  localparam int NP = 40;
  localparam int NW = (NP + 31) / 32;
  localparam int G_PEND = 0, G_ACK = 1, G_MASK = 2, G_MODE = 5, G_FRC = 8, G_HOLE = 11, G_ACTV = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          bus_wr = 1'b0;
  logic [10:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  xint_ctrl #(.NUM_PINS(NP)) i_xint_ctrl (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pins_i      (pins),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq)
  );

  function automatic logic [10:0] ga(int g, int w);
    return 11'(g * 64 + w * 4);
  endfunction

  function automatic logic [10:0] da(int dom, int w);
    return 11'(1024 + dom * 32 + w * 4);
  endfunction

  function automatic logic [31:0] vword(int w);
    int bits = NP - 32 * w;
    if (w >= NW) return 32'h0;
    if (bits >= 32) return 32'hFFFF_FFFF;
    return (32'h1 << bits) - 32'h1;
  endfunction

  // Expected pending after an acknowledge while input sits at a given level
  function automatic logic exp_after_ack(logic level_mode, logic at_active);
    return level_mode & at_active;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [31:0] d);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  task automatic rd_bit(input int p, output logic b);
    logic [31:0] d;
    rd(ga(G_PEND, p / 32), d);
    b = d[p % 32];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pins  = '0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(4);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  logic [31:0] mdl [6][NW];
  logic [31:0] d;
  logic        b;

  initial begin
    void'($urandom(32'd20240917));
    do_reset();

    // ---- R1 reset state
    for (int w = 0; w < NW; w++) begin
      rd(ga(G_MASK, w), d); check("R1 mask", d, vword(w));
      rd(ga(G_MODE, w), d); check("R1 mode", d, 32'h0);
      rd(ga(G_ACTV, w), d); check("R1 active", d, 32'h0);
      rd(ga(G_FRC, w), d);  check("R1 force", d, 32'h0);
      rd(ga(G_PEND, w), d); check("R1 status", d, 32'h0);
      rd(da(0, w), d);      check("R1 dom0", d, 32'h0);
      rd(da(1, w), d);      check("R1 dom1", d, 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 32'h0);

    // ---- R2 / R11 map corners
    wr(ga(G_ACTV + 1, 1), 32'hFFFF_FFFF);
    rd(ga(G_ACTV, 1), d);  check("R11 upper pins", d, vword(1));
    wr(ga(G_HOLE, 0), 32'hFFFF_FFFF);
    rd(ga(G_HOLE, 0), d);  check("R2 reserved group", d, 32'h0);
    wr(ga(G_ACTV + 1, 2), 32'hFFFF_FFFF);
    rd(ga(G_ACTV, 2), d);  check("R11 word beyond", d, 32'h0);
    rd(ga(G_ACTV + 2, 1), d); check("R3 clear alias reads field", d, vword(1));
    wr(ga(G_ACTV + 2, 1), 32'hFFFF_FFFF);
    rd(ga(G_ACTV, 1), d);  check("R2 active word1 cleared", d, 32'h0);

    // ---- R3 / R11 random register traffic against a bench model
    for (int w = 0; w < NW; w++)
      for (int f = 0; f < 6; f++) mdl[f][w] = (f == 0) ? vword(w) : 32'h0;
    for (int it = 0; it < 240; it++) begin
      int f  = int'($urandom % 6);
      int op = int'($urandom % 3);
      int w  = int'($urandom % (NW + 1));
      int rs = int'($urandom % 2);
      logic [31:0] v = $urandom;
      logic [10:0] wa, ra;
      int base;
      base = (f == 0) ? G_MASK : (f == 1) ? G_MODE : (f == 2) ? G_FRC : G_ACTV;
      if (f >= 4) begin
        wa = da(f - 4, w);
        ra = wa;
        if (w < NW) mdl[f][w] = v & vword(w);
      end else begin
        wa = ga(base + ((op == 2) ? 0 : op + 1), w);
        ra = ga(base + rs, w);
        if (w < NW) begin
          if (op == 0) mdl[f][w] = mdl[f][w] | (v & vword(w));
          if (op == 1) mdl[f][w] = mdl[f][w] & ~v;
        end
      end
      wr(wa, v);
      rd(ra, d);
      check("R3 random field readback", d, (w < NW) ? mdl[f][w] : 32'h0);
    end

    // ---- R6 / R4 latency on pin 3, rising edge
    do_reset();
    wr(ga(G_ACTV + 1, 0), 32'h8);
    bus_addr = ga(G_PEND, 0);
    @(negedge clk);
    pins[3] = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    check("R6 not after second edge", {31'b0, bus_rdata[3]}, 32'h0);
    @(posedge clk); #2;
    check("R6 visible after third edge", {31'b0, bus_rdata[3]}, 32'h1);
    @(negedge clk);
    pins[3] = 1'b0;
    wait_clk(6);
    rd_bit(3, b); check("R4 edge latched after return", {31'b0, b}, 32'h1);
    wr(ga(G_ACK, 0), 32'h0);
    rd_bit(3, b); check("R7 zero ack no effect", {31'b0, b}, 32'h1);
    wr(ga(G_PEND, 0), 32'h0);
    rd_bit(3, b); check("R7 status write ignored", {31'b0, b}, 32'h1);
    wr(ga(G_ACK, 0), 32'h8);
    rd_bit(3, b); check("R7 ack clears", {31'b0, b}, 32'h0);

    // ---- R8 transition and acknowledge in the same cycle
    @(negedge clk);
    pins[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    wr(ga(G_ACK, 0), 32'h8);
    rd_bit(3, b); check("R8 edge beats ack", {31'b0, b}, 32'h1);
    wr(ga(G_ACK, 0), 32'h8);
    rd_bit(3, b); check("R8 later ack clears", {31'b0, b}, 32'h0);

    // ---- R9 force on pin 35
    wr(ga(G_FRC + 1, 1), 32'h8);
    wait_clk(2);
    rd_bit(35, b); check("R9 force pends", {31'b0, b}, 32'h1);
    wr(ga(G_ACK, 1), 32'h8);
    wait_clk(1);
    rd_bit(35, b); check("R9 ack does not clear forced", {31'b0, b}, 32'h1);
    wr(ga(G_FRC + 2, 1), 32'h8);
    wr(ga(G_ACK, 1), 32'h8);
    wait_clk(1);
    rd_bit(35, b); check("R9 ack after force-clear", {31'b0, b}, 32'h0);

    // ---- R10 combined request, pin 35 pending through force
    wr(ga(G_FRC + 1, 1), 32'h8);
    wr(ga(G_MASK + 2, 1), 32'h8);
    wr(da(1, 1), 32'h8);
    wait_clk(1);
    check("R10 domain1 has no effect", {31'b0, irq}, 32'h0);
    wr(da(0, 1), 32'h8);
    check("R10 enabled unmasked pending", {31'b0, irq}, 32'h1);
    wr(ga(G_MASK + 1, 1), 32'h8);
    check("R10 masked", {31'b0, irq}, 32'h0);
    wr(ga(G_FRC + 2, 1), 32'h8);
    wr(ga(G_ACK, 1), 32'h8);
    wr(da(0, 1), 32'h0);

    // ---- R4 / R5 / R7 / R10 random pin events
    for (int it = 0; it < 30; it++) begin
      int p      = int'($urandom % NP);
      logic lvl  = 1'($urandom);
      logic act  = 1'($urandom);
      int w      = p / 32;
      logic [31:0] bm = 32'h1 << (p % 32);
      string tg  = lvl ? "R5" : "R4";
      wr(ga(lvl ? G_MODE + 1 : G_MODE + 2, w), bm);
      wr(ga(act ? G_ACTV + 1 : G_ACTV + 2, w), bm);
      pins[p] = ~act;
      wait_clk(6);
      wr(ga(G_ACK, w), bm);
      wait_clk(1);
      rd_bit(p, b); check({"R7 idle after ack ", tg}, {31'b0, b}, 32'h0);
      wr(ga(G_MASK + 2, w), bm);
      wr(da(0, w), bm);
      check("R10 quiet when nothing pending", {31'b0, irq}, 32'h0);
      pins[p] = act;
      wait_clk(6);
      rd_bit(p, b); check({tg, " event pends"}, {31'b0, b}, 32'h1);
      check("R10 request raised", {31'b0, irq}, 32'h1);
      wr(ga(G_ACK, w), bm);
      wait_clk(1);
      rd_bit(p, b);
      check({tg, " ack while active"}, {31'b0, b}, {31'b0, exp_after_ack(lvl, 1'b1)});
      pins[p] = ~act;
      wait_clk(6);
      wr(ga(G_ACK, w), bm);
      wait_clk(1);
      rd_bit(p, b);
      check({tg, " ack after return"}, {31'b0, b}, {31'b0, exp_after_ack(lvl, 1'b0)});
      wr(ga(G_MASK + 1, w), bm);
      wr(da(0, w), 32'h0);
    end

    summary();
    $finish;
  end

endmodule